// File: doc/BRIEF.md
# Radio Power-State Sequencer

This block steps a radio transceiver through its operating states: sleep, wake-up, synthesizer calibration, idle, transmit and receive. A host issues transmit, receive and sleep commands. A wake pin or a falling edge on the chip-select line brings the radio out of sleep. While the crystal oscillator starts, the block holds a device reset low. It then waits for the synthesizer calibration to report done and settles in idle.

When a transmission or reception ends, a per-direction auto-sleep bit selects the next state. If the bit is set and no interrupt is pending, the radio drops to sleep; otherwise it returns to idle. A sleep command that arrives during transmit or receive is held until that operation ends. During receive the block follows the frame through four phases, one after another.

The analog side is modelled only by its done, detect and frame-end inputs. Both wake-up timers are counted in system clock cycles. Their parameters can therefore be made short for simulation.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `state_o` is SLEEP and `ext_en`, `dev_rst_n` and `rx_phase_o` are all 0. State codes: SLEEP=0, WAKEUP=1, INIT=2, IDLE=3, TX=4, RX=5.
- R2: In SLEEP, the cycle after `wake_pin` is high, or after `cs_n` is sampled low having been high on the previous clock, the state is WAKEUP. A `cs_n` that stays low with no falling edge does not wake the block.
- R3: `ext_en` rises in the same cycle the state becomes WAKEUP. It stays high in every state except SLEEP and falls in the same cycle the state becomes SLEEP.
- R4: WAKEUP lasts exactly `XTAL_CYC` cycles and is followed by INIT.
- R5: `dev_rst_n` is low in SLEEP and during the first `RST_CYC` cycles of WAKEUP. It is high from then on until the next SLEEP.
- R6: INIT moves to IDLE the cycle after `cal_done` is high and holds until then.
- R7: In IDLE, `cmd_tx` wins over `cmd_rx`, and `cmd_rx` wins over `cmd_sleep`. The chosen state follows on the next cycle.
- R8: When `tx_done` is high in TX, the next state is SLEEP if `auto_sleep_tx` is 1 and `irq_pending` is 0. Otherwise it is IDLE.
- R9: When `rx_frame_end` is high in RX, in any phase, the next state is SLEEP if `auto_sleep_rx` is 1 and `irq_pending` is 0. Otherwise it is IDLE.
- R10: `rx_phase_o` encodes HUNT=0, SFD=1, HEADER=2, DATA=3. It is 0 on entering RX and outside RX. It advances HUNT→SFD on `rx_preamble_det`, SFD→HEADER on `rx_sfd_det`, and HEADER→DATA on `rx_phr_ok`. A detect input that does not match the current phase has no effect.
- R11: A `cmd_sleep` given in TX or RX does not change the state at once. When that operation ends, the next state is SLEEP whatever the auto-sleep bits and `irq_pending` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin | input | 1 | Level wake request |
| cs_n | input | 1 | Host chip select; a falling edge wakes the block |
| cmd_tx | input | 1 | Transmit command pulse |
| cmd_rx | input | 1 | Receive command pulse |
| cmd_sleep | input | 1 | Sleep command pulse |
| cal_done | input | 1 | Synthesizer calibration finished |
| tx_done | input | 1 | Frame transmission finished |
| rx_preamble_det | input | 1 | Preamble detected |
| rx_sfd_det | input | 1 | Start-of-frame delimiter found |
| rx_phr_ok | input | 1 | Header decoded |
| rx_frame_end | input | 1 | Reception ended (good, error or timeout) |
| irq_pending | input | 1 | A host interrupt is outstanding |
| auto_sleep_tx | input | 1 | Sleep after transmit when no interrupt is pending |
| auto_sleep_rx | input | 1 | Sleep after receive when no interrupt is pending |
| ext_en | output | 1 | External enable, high outside SLEEP |
| dev_rst_n | output | 1 | Active-low device reset |
| state_o | output | 3 | Current state code |
| rx_phase_o | output | 2 | Current receive phase code |

## Verification
A wrong state register appears on `state_o` and `ext_en` on the cycle after the edge that caused it. The bench therefore catches a misrouted end-of-operation decision one cycle after `tx_done` or `rx_frame_end`. A miscounted wake-up timer shifts the `dev_rst_n` rise or the change to INIT by at least one cycle, and both are sampled at their exact expected cycles. A deferred-sleep flag that is lost or left stuck shows up only at the end of the next TX or RX, where the state goes the wrong way.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_WAKEUP = 3'd1,
    ST_INIT   = 3'd2,
    ST_IDLE   = 3'd3,
    ST_TX     = 3'd4,
    ST_RX     = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    RXP_HUNT = 2'd0,
    RXP_SFD  = 2'd1,
    RXP_HDR  = 2'd2,
    RXP_DATA = 2'd3
  } rx_phase_e;

  // Decision at the end of a transmit or receive: sleep when asked by the
  // host earlier, or when auto-sleep is on and nothing awaits service.
  function automatic logic end_goes_to_sleep(input logic auto_bit,
                                             input logic irq,
                                             input logic deferred);
    return deferred | (auto_bit & ~irq);
  endfunction

endpackage

// File: rtl/rps_wake_detect.sv
module rps_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_pin,
  input  logic cs_n,
  output logic wake_evt
);
  logic cs_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev_q <= 1'b1;
    else        cs_prev_q <= cs_n;
  end

  logic cs_fall;
  assign cs_fall  = cs_prev_q & ~cs_n;
  assign wake_evt = wake_pin | cs_fall;

  // R2: a chip-select edge needs the line high on the previous clock
  p_cs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall) |-> $past(cs_n));
endmodule

// File: rtl/rps_wake_timer.sv
module rps_wake_timer #(
  parameter int XTAL_CYC = 1000000,
  parameter int RST_CYC  = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic xtal_done,
  output logic rst_release
);
  localparam int CW = (XTAL_CYC > 2) ? $clog2(XTAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(XTAL_CYC - 1);
  localparam logic [CW-1:0] RREL = CW'(RST_CYC);

  logic [CW-1:0] cnt_q;

  function automatic logic at_last(input logic [CW-1:0] c);
    return c == LAST;
  endfunction

  function automatic logic past_reset(input logic [CW-1:0] c);
    return c >= RREL;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!run)                cnt_q <= '0;
    else if (!at_last(cnt_q))     cnt_q <= cnt_q + 1'b1;
  end

  assign xtal_done   = run & at_last(cnt_q);
  assign rst_release = run & past_reset(cnt_q);

  // R4: the count never runs past the crystal window
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R5: reset release only once the reset window is over and the crystal done implies it
  p_done_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_done |-> rst_release);
endmodule

// File: rtl/rps_rx_phase.sv
module rps_rx_phase
  import radio_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      pre_det,
  input  logic      sfd_det,
  input  logic      phr_ok,
  input  logic      frame_end,
  output rx_phase_e phase
);
  rx_phase_e phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    if (!active || frame_end) phase_n = RXP_HUNT;
    else begin
      unique case (phase_q)
        RXP_HUNT: if (pre_det) phase_n = RXP_SFD;
        RXP_SFD:  if (sfd_det) phase_n = RXP_HDR;
        RXP_HDR:  if (phr_ok)  phase_n = RXP_DATA;
        default:  phase_n = RXP_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= RXP_HUNT;
    else        phase_q <= phase_n;
  end

  assign phase = phase_q;

  // R10: the phase either steps forward by one or falls back to hunt
  p_phase_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q) && phase_q != RXP_HUNT)
      |-> (2'(phase_q) == 2'($past(phase_q)) + 2'd1));
  // R10: outside receive the phase stays at hunt
  p_phase_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> phase_q == RXP_HUNT);
endmodule

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl
  import radio_pwr_pkg::*;
#(
  parameter int XTAL_CYC = 1000000,
  parameter int RST_CYC  = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_pin,
  input  logic       cs_n,
  input  logic       cmd_tx,
  input  logic       cmd_rx,
  input  logic       cmd_sleep,
  input  logic       cal_done,
  input  logic       tx_done,
  input  logic       rx_preamble_det,
  input  logic       rx_sfd_det,
  input  logic       rx_phr_ok,
  input  logic       rx_frame_end,
  input  logic       irq_pending,
  input  logic       auto_sleep_tx,
  input  logic       auto_sleep_rx,
  output logic       ext_en,
  output logic       dev_rst_n,
  output logic [2:0] state_o,
  output logic [1:0] rx_phase_o
);
  pwr_state_e state_q, state_n;
  logic       defer_q;
  logic       ext_en_q;
  logic       wake_evt, xtal_done, rst_release;
  logic       busy, op_end, sleep_now;
  rx_phase_e  phase;

  rps_wake_detect u_wake (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .cs_n(cs_n),
    .wake_evt(wake_evt)
  );

  rps_wake_timer #(.XTAL_CYC(XTAL_CYC), .RST_CYC(RST_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAKEUP),
    .xtal_done(xtal_done), .rst_release(rst_release)
  );

  rps_rx_phase u_rxp (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_RX),
    .pre_det(rx_preamble_det), .sfd_det(rx_sfd_det), .phr_ok(rx_phr_ok),
    .frame_end(rx_frame_end), .phase(phase)
  );

  assign busy   = (state_q == ST_TX) || (state_q == ST_RX);
  assign op_end = ((state_q == ST_TX) && tx_done) ||
                  ((state_q == ST_RX) && rx_frame_end);
  assign sleep_now = (state_q == ST_TX)
      ? end_goes_to_sleep(auto_sleep_tx, irq_pending, defer_q | cmd_sleep)
      : end_goes_to_sleep(auto_sleep_rx, irq_pending, defer_q | cmd_sleep);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_SLEEP:  if (wake_evt)  state_n = ST_WAKEUP;
      ST_WAKEUP: if (xtal_done) state_n = ST_INIT;
      ST_INIT:   if (cal_done)  state_n = ST_IDLE;
      ST_IDLE: begin
        if (cmd_tx)         state_n = ST_TX;
        else if (cmd_rx)    state_n = ST_RX;
        else if (cmd_sleep) state_n = ST_SLEEP;
      end
      ST_TX, ST_RX: if (op_end) state_n = sleep_now ? ST_SLEEP : ST_IDLE;
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SLEEP;
      defer_q  <= 1'b0;
      ext_en_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      ext_en_q <= (state_n != ST_SLEEP);
      if (!busy || op_end) defer_q <= 1'b0;
      else if (cmd_sleep)  defer_q <= 1'b1;
    end
  end

  assign ext_en     = ext_en_q;
  assign dev_rst_n  = rst_release ||
                      (state_q != ST_SLEEP && state_q != ST_WAKEUP);
  assign state_o    = state_q;
  assign rx_phase_o = phase;

  // R2: sleep is left only on a wake event
  p_stay_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !wake_evt) |=> state_q == ST_SLEEP);
  // R3: external enable rises only on entry to wake-up
  p_ext_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_en) |-> state_q == ST_WAKEUP);
  // R3: external enable is low only while asleep
  p_ext_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> state_q == ST_SLEEP);
  // R5: device reset releases inside wake-up
  p_rst_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> state_q == ST_WAKEUP);
  // R6: calibration waits for done
  p_init_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && !cal_done) |=> state_q == ST_INIT);
  // R11: a sleep request in flight never leaves the operation early
  p_defer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_sleep && !op_end) |=> state_q == $past(state_q));
  // R11: a held sleep request ends in sleep
  p_defer_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_q && op_end) |=> state_q == ST_SLEEP);
endmodule

// File: tb/radio_pwr_ctrl_tb.sv
module radio_pwr_ctrl_tb;
  localparam int XC = 20;
  localparam int RC = 15;
  localparam int S_SLEEP = 0, S_WAKE = 1, S_INIT = 2, S_IDLE = 3, S_TX = 4, S_RX = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_pin = 0, cs_n = 1, cmd_tx = 0, cmd_rx = 0, cmd_sleep = 0;
  logic cal_done = 0, tx_done = 0, rx_preamble_det = 0, rx_sfd_det = 0;
  logic rx_phr_ok = 0, rx_frame_end = 0, irq_pending = 0;
  logic auto_sleep_tx = 0, auto_sleep_rx = 0;
  logic ext_en, dev_rst_n;
  logic [2:0] state_o;
  logic [1:0] rx_phase_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  radio_pwr_ctrl #(.XTAL_CYC(XC), .RST_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .cs_n(cs_n),
    .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_sleep(cmd_sleep),
    .cal_done(cal_done), .tx_done(tx_done),
    .rx_preamble_det(rx_preamble_det), .rx_sfd_det(rx_sfd_det),
    .rx_phr_ok(rx_phr_ok), .rx_frame_end(rx_frame_end),
    .irq_pending(irq_pending), .auto_sleep_tx(auto_sleep_tx),
    .auto_sleep_rx(auto_sleep_rx), .ext_en(ext_en), .dev_rst_n(dev_rst_n),
    .state_o(state_o), .rx_phase_o(rx_phase_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int end_target(input bit auto_b, input bit irq, input bit deferred);
    if (deferred) return S_SLEEP;
    if (auto_b && !irq) return S_SLEEP;
    return S_IDLE;
  endfunction

  task automatic bring_up();
    wake_pin = 1; step(); wake_pin = 0;
    step(XC);
    cal_done = 1; step(); cal_done = 0;
  endtask

  task automatic t_reset();
    check("R1 state", state_o, S_SLEEP);
    check("R1 ext_en", ext_en, 0);
    check("R1 dev_rst_n", dev_rst_n, 0);
    check("R1 rx_phase", rx_phase_o, 0);
  endtask

  task automatic t_wake_pin();
    step(3);
    check("R2 idle sleep", state_o, S_SLEEP);
    wake_pin = 1; step(); wake_pin = 0;
    check("R2 wake pin", state_o, S_WAKE);
    check("R3 ext_en rise", ext_en, 1);
    check("R5 rst low entry", dev_rst_n, 0);
    step(RC - 1);
    check("R5 rst low last", dev_rst_n, 0);
    step();
    check("R5 rst released", dev_rst_n, 1);
    step(XC - 1 - RC);
    check("R4 still wakeup", state_o, S_WAKE);
    step();
    check("R4 init after xtal", state_o, S_INIT);
    cmd_tx = 1; step(2); cmd_tx = 0;
    check("R6 init holds", state_o, S_INIT);
    cal_done = 1; step(); cal_done = 0;
    check("R6 idle", state_o, S_IDLE);
    check("R3 ext_en idle", ext_en, 1);
  endtask

  task automatic t_priority();
    cmd_tx = 1; cmd_rx = 1; cmd_sleep = 1; step();
    cmd_tx = 0; cmd_rx = 0; cmd_sleep = 0;
    check("R7 tx wins", state_o, S_TX);
    tx_done = 1; step(); tx_done = 0;
    check("R8 tx to idle", state_o, end_target(0, 0, 0));
    cmd_rx = 1; cmd_sleep = 1; step(); cmd_rx = 0; cmd_sleep = 0;
    check("R7 rx over sleep", state_o, S_RX);
    rx_frame_end = 1; step(); rx_frame_end = 0;
    check("R9 rx end idle", state_o, S_IDLE);
  endtask

  task automatic t_tx_autosleep();
    auto_sleep_tx = 1; irq_pending = 1;
    cmd_tx = 1; step(); cmd_tx = 0;
    tx_done = 1; step(); tx_done = 0;
    check("R8 irq blocks sleep", state_o, end_target(1, 1, 0));
    irq_pending = 0;
    cmd_tx = 1; step(); cmd_tx = 0;
    tx_done = 1; step(); tx_done = 0;
    check("R8 auto sleep", state_o, end_target(1, 0, 0));
    check("R3 ext_en falls", ext_en, 0);
    check("R5 rst low asleep", dev_rst_n, 0);
    auto_sleep_tx = 0;
  endtask

  task automatic t_cs_edge();
    cs_n = 0; step();
    check("R2 cs edge", state_o, S_WAKE);
    step(XC);
    cal_done = 1; step(); cal_done = 0;
    cmd_sleep = 1; step(); cmd_sleep = 0;
    check("R7 sleep cmd", state_o, S_SLEEP);
    step(4);
    check("R2 cs held low", state_o, S_SLEEP);
    cs_n = 1; step(); cs_n = 0; step();
    check("R2 cs second edge", state_o, S_WAKE);
    cs_n = 1;
    step(XC);
    cal_done = 1; step(); cal_done = 0;
  endtask

  task automatic t_rx_phases();
    auto_sleep_rx = 1;
    cmd_rx = 1; step(); cmd_rx = 0;
    check("R10 entry hunt", rx_phase_o, 0);
    rx_sfd_det = 1; rx_phr_ok = 1; step(); rx_sfd_det = 0; rx_phr_ok = 0;
    check("R10 out of order ignored", rx_phase_o, 0);
    rx_preamble_det = 1; step(); rx_preamble_det = 0;
    check("R10 sfd phase", rx_phase_o, 1);
    rx_phr_ok = 1; step(); rx_phr_ok = 0;
    check("R10 phr ignored in sfd", rx_phase_o, 1);
    rx_sfd_det = 1; step(); rx_sfd_det = 0;
    check("R10 header phase", rx_phase_o, 2);
    rx_phr_ok = 1; step(); rx_phr_ok = 0;
    check("R10 data phase", rx_phase_o, 3);
    rx_frame_end = 1; step(); rx_frame_end = 0;
    check("R9 rx auto sleep", state_o, end_target(1, 0, 0));
    check("R10 phase cleared", rx_phase_o, 0);
    auto_sleep_rx = 0;
    bring_up();
    cmd_rx = 1; step(); cmd_rx = 0;
    rx_preamble_det = 1; step(); rx_preamble_det = 0;
    rx_frame_end = 1; step(); rx_frame_end = 0;
    check("R9 early end idle", state_o, S_IDLE);
  endtask

  task automatic t_defer();
    irq_pending = 1;
    cmd_tx = 1; step(); cmd_tx = 0;
    cmd_sleep = 1; step(); cmd_sleep = 0;
    check("R11 tx continues", state_o, S_TX);
    step(2);
    tx_done = 1; step(); tx_done = 0;
    check("R11 deferred tx sleep", state_o, end_target(0, 1, 1));
    bring_up();
    cmd_rx = 1; step(); cmd_rx = 0;
    cmd_sleep = 1; step(); cmd_sleep = 0;
    check("R11 rx continues", state_o, S_RX);
    rx_frame_end = 1; step(); rx_frame_end = 0;
    check("R11 deferred rx sleep", state_o, S_SLEEP);
    bring_up();
    cmd_tx = 1; step(); cmd_tx = 0;
    tx_done = 1; step(); tx_done = 0;
    check("R11 flag cleared", state_o, S_IDLE);
    irq_pending = 0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(2);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_wake_pin();
    t_priority();
    t_tx_autosleep();
    t_cs_edge();
    t_rx_phases();
    t_defer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule